// File: doc/BRIEF.md
# Frame-Restarted Byte Derandomizer

This block strips the pseudo-random pattern from a byte stream that is already frame aligned. Every data byte at or beyond a programmable position in its frame is XORed with eight successive bits of a maximal-length sequence. The sequence comes from an 8-bit shift-register generator with the characteristic polynomial h(x) = x^8 + x^7 + x^5 + x^3 + 1. The generator is reseeded at every start-of-frame. The bytes that lie ahead of the programmed position, such as trailing marker or header bytes, leave the block untouched.

XOR with a fixed sequence undoes itself, so the same block also adds the pattern on the transmit path. The enable input turns the XOR off. In that case bytes pass through with the same latency as when the XOR is on. Every output is registered, and the output stream trails the input by exactly one clock.

Top module: `frame_descrambler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, outValid and outSof are 0.
- R2: outValid equals inValid one clock earlier, and outSof equals (inValid and inSof) one clock earlier. Output bytes appear in input order.
- R3: At each valid byte with inSof high, the generator is reseeded to all ones. With offset 0 and enable high, the start-of-frame byte therefore leaves as inData XOR 0xFF.
- R4: A valid byte whose index within the frame is below the effective offset leaves unchanged. The start-of-frame byte has index 0.
- R5: Bytes at or past the offset are XORed with the sequence a(n+8) = a(n+7) ^ a(n+5) ^ a(n+3) ^ a(n), where a(0..7) = 1. The first bit in time lands on bit 7 of the byte. The pattern runs across more than one 255-bit period within a frame without a break.
- R6: Cycles with inValid low do not advance the generator or the byte index. Gaps therefore leave the output sequence unchanged.
- R7: With enable low, every valid byte leaves unchanged with the same one-cycle latency.
- R8: Offset values above 8 behave exactly as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 1: apply XOR; 0: pass-through |
| offset | input | 4 | Count of leading frame bytes left unaltered (0..8, larger values clamp to 8) |
| inValid | input | 1 | Input byte qualifier |
| inSof | input | 1 | Marks the first byte of a frame (qualified by inValid) |
| inData | input | 8 | Input byte |
| outValid | output | 1 | Output byte qualifier |
| outSof | output | 1 | First byte of an output frame |
| outData | output | 8 | Output byte |

## Verification
The assertions assume that enable and offset stay steady within a frame. They also assume that inSof is only meaningful together with inValid. The stimulus changes these settings only between frames, and it always opens the stream with a start-of-frame byte. Frames mix back-to-back bytes with idle gaps, use offsets at 0, mid-range, 8 and beyond 8, and include a frame long enough to wrap the 255-bit sequence. Every output byte is compared with a bit-serial model of the recurrence.

// File: rtl/descr_pkg.sv
package descr_pkg;
  localparam int GEN_W = 8;
  localparam int BYTE_W = 8;
  localparam logic [GEN_W-1:0] GEN_SEED = '1;

  typedef struct packed {
    logic load;     // reseed generator this byte
    logic advance;  // step generator by one byte
    logic apply;    // XOR the mask onto the data
  } strobe_t;
endpackage

// File: rtl/descr_ctrl.sv
module descr_ctrl
  import descr_pkg::*;
#(
  parameter int OFFSET_W = 4,
  parameter int MAX_OFFSET = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [OFFSET_W-1:0] offset,
  input  logic                inValid,
  input  logic                inSof,
  output strobe_t             strobe
);
  localparam int CNT_W = $clog2(MAX_OFFSET + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OFFSET);

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] byteIdx;
  logic [CNT_W-1:0] offEff;
  logic             pastOffset;

  always_comb begin
    if (int'(offset) > MAX_OFFSET) offEff = CNT_MAX;
    else                           offEff = CNT_W'(offset);
    byteIdx    = inSof ? '0 : byteCnt;
    pastOffset = (byteIdx >= offEff);
    strobe.load    = inValid && inSof;
    strobe.advance = inValid && pastOffset;
    strobe.apply   = inValid && pastOffset && enable;
  end

  // index of the next byte within the frame, saturating at the largest offset
  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt <= '0;
    end else if (inValid) begin
      byteCnt <= (byteIdx >= CNT_MAX) ? CNT_MAX : byteIdx + 1'b1;
    end
  end
endmodule

// File: rtl/descr_dp.sv
module descr_dp
  import descr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic              inValid,
  input  logic              inSof,
  input  logic [BYTE_W-1:0] inData,
  output logic              outValid,
  output logic              outSof,
  output logic [BYTE_W-1:0] outData
);
  logic [GEN_W-1:0]  genState;
  logic [GEN_W-1:0]  curState;
  logic [GEN_W-1:0]  nextState;
  logic [BYTE_W-1:0] mask;

  // state bit 7 holds the oldest sequence bit, bit 0 the newest
  always_comb begin
    logic [GEN_W-1:0] st;
    logic fb;
    curState = strobe.load ? GEN_SEED : genState;
    st = curState;
    mask = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      mask[i] = st[7];
      fb = st[0] ^ st[2] ^ st[4] ^ st[7];
      st = {st[GEN_W-2:0], fb};
    end
    nextState = st;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      genState <= GEN_SEED;
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outData  <= '0;
    end else begin
      if (strobe.advance)   genState <= nextState;
      else if (strobe.load) genState <= GEN_SEED;
      outValid <= inValid;
      outSof   <= inValid && inSof;
      outData  <= strobe.apply ? (inData ^ mask) : inData;
    end
  end
endmodule

// File: rtl/frame_descrambler.sv
module frame_descrambler
  import descr_pkg::*;
#(
  parameter int OFFSET_W = 4,
  parameter int MAX_OFFSET = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [OFFSET_W-1:0] offset,
  input  logic                inValid,
  input  logic                inSof,
  input  logic [7:0]          inData,
  output logic                outValid,
  output logic                outSof,
  output logic [7:0]          outData
);
  strobe_t strobe;

  descr_ctrl #(.OFFSET_W(OFFSET_W), .MAX_OFFSET(MAX_OFFSET)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .offset(offset),
    .inValid(inValid), .inSof(inSof), .strobe(strobe)
  );

  descr_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inValid(inValid), .inSof(inSof), .inData(inData),
    .outValid(outValid), .outSof(outSof), .outData(outData)
  );
endmodule

// File: rtl/descr_chk.sv
module descr_chk #(
  parameter int OFFSET_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                enable,
  input logic [OFFSET_W-1:0] offset,
  input logic                inValid,
  input logic                inSof,
  input logic [7:0]          inData,
  input logic                outValid,
  input logic                outSof,
  input logic [7:0]          outData
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (!outValid && !outSof));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !outSof));

  a_r2_sof_follows: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSof) |=> outSof);

  a_r3_seed_byte: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSof && enable && offset == '0) |=> (outData == ($past(inData) ^ 8'hFF)));

  a_r4_head_untouched: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSof && offset != '0) |=> (outData == $past(inData)));

  a_r7_bypass: assert property (@(posedge clk) disable iff (rst)
    (inValid && !enable) |=> (outData == $past(inData)));
endmodule

bind frame_descrambler descr_chk #(.OFFSET_W(OFFSET_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .offset(offset),
  .inValid(inValid), .inSof(inSof), .inData(inData),
  .outValid(outValid), .outSof(outSof), .outData(outData)
);

// File: tb/sim_frame_descrambler.sv
module sim_frame_descrambler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b1;
  logic [3:0] offset = '0;
  logic       inValid = 1'b0;
  logic       inSof = 1'b0;
  logic [7:0] inData = '0;
  logic       outValid;
  logic       outSof;
  logic [7:0] outData;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic  expSof[$];
  logic [7:0] expData[$];
  string expTag[$];

  logic seqBits[0:511];

  always #2.5 clk = ~clk;

  frame_descrambler u0 (
    .clk(clk), .rst(rst), .enable(enable), .offset(offset),
    .inValid(inValid), .inSof(inSof), .inData(inData),
    .outValid(outValid), .outSof(outSof), .outData(outData)
  );

  // bit-serial reference of the recurrence (R5)
  task automatic buildSeq();
    for (int n = 0; n < 8; n++) seqBits[n] = 1'b1;
    for (int n = 8; n < 512; n++)
      seqBits[n] = seqBits[n-1] ^ seqBits[n-3] ^ seqBits[n-5] ^ seqBits[n-8];
  endtask

  task automatic idleCycle();
    @(posedge clk); #1;
    inValid = 1'b0; inSof = 1'b0; inData = 8'($urandom);
  endtask

  task automatic sendFrame(int len, int off, bit en, int gapEvery, string tag);
    int eff;
    int pos;
    eff = (off > 8) ? 8 : off;
    pos = 0;
    @(posedge clk); #1;
    enable = en; offset = 4'(off); inValid = 1'b0;
    for (int b = 0; b < len; b++) begin
      logic [7:0] d;
      logic [7:0] m;
      logic [7:0] e;
      string t;
      if (gapEvery != 0 && (b % gapEvery) == 1) idleCycle();
      d = 8'($urandom);
      m = '0;
      t = tag;
      if (b >= eff) begin
        for (int k = 0; k < 8; k++) m[7-k] = seqBits[pos+k];
        pos += 8;
        if (tag == "") t = en ? "R5" : "R7";
      end else if (tag == "") begin
        t = "R4";
      end
      e = en ? (d ^ m) : d;
      if (b == 0 && eff == 0 && en && tag == "") t = "R3";
      expSof.push_back(b == 0);
      expData.push_back(e);
      expTag.push_back(t);
      @(posedge clk); #1;
      inValid = 1'b1; inSof = (b == 0); inData = d;
    end
    @(posedge clk); #1;
    inValid = 1'b0; inSof = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && outValid) begin
      tests++;
      if (expData.size() == 0) begin
        fails++;
        $display("FAIL R2: output byte %h with no pending item (expected none)", outData);
      end else begin
        logic s;
        logic [7:0] e;
        string t;
        s = expSof.pop_front();
        e = expData.pop_front();
        t = expTag.pop_front();
        if (outData !== e || outSof !== s) begin
          fails++;
          $display("FAIL %s: data=%h sof=%b expected data=%h sof=%b", t, outData, outSof, e, s);
        end
      end
    end
  end

  initial begin
    buildSeq();
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++; // R1: outputs idle during reset
        if (outValid !== 1'b0 || outSof !== 1'b0) begin
          fails++;
          $display("FAIL R1: outValid=%b outSof=%b expected 0 0", outValid, outSof);
        end
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        tests++; // R1: first cycle after reset
        if (outValid !== 1'b0 || outSof !== 1'b0) begin
          fails++;
          $display("FAIL R1: after reset outValid=%b outSof=%b expected 0 0", outValid, outSof);
        end
        sendFrame(40, 0, 1'b1, 0, "");       // R3, R5 across the period
        sendFrame(12, 3, 1'b1, 2, "R6");     // gaps, R6
        sendFrame(20, 8, 1'b1, 0, "");       // R4 at the largest offset
        sendFrame(20, 12, 1'b1, 0, "R8");    // clamps to 8
        sendFrame(16, 2, 1'b0, 3, "");       // R7 bypass
        sendFrame(40, 5, 1'b1, 4, "");       // mixed
        sendFrame(3, 0, 1'b1, 0, "");        // short frame, reseed again R3
        repeat (4) @(posedge clk);
        @(negedge clk);
        tests++; // R2: every pushed byte came out
        if (expData.size() != 0) begin
          fails++;
          $display("FAIL R2: %0d bytes missing, expected 0", expData.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R2: watchdog expired, pending=%0d expected 0", expData.size());
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule